// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the processor-facing shell around an I2C master bit engine. A word-addressed register port lets software program a clock divider, a control word carrying the mode bits and the transfer byte count, a target address and a command. Writing a command with its start bit set hands a launch pulse to the engine. Two byte-wide FIFOs, each 128 entries deep, sit between software and the engine. Software fills the transmit FIFO and the engine drains it. The engine fills the receive FIFO and software drains it.

The block gathers engine events and its own FIFO conditions into a sticky status register, cleared by writing ones. Each status bit has an enable bit. One registered interrupt line is raised when any enabled status bit is set. A soft-reset bit in the control word clears the whole front end. A flush bit in the FIFO control word empties both FIFOs, and the same word sets a receive high-water threshold.

Top module: `i2cm_csr_front`

## Requirements
- R1: After the synchronous reset every readable register returns 0, the interrupt is low and the launch pulse is low.
- R2: Words written to the divider (offset 0x0), target (0xA) and control (0x1) read back one cycle after the read request, with control bit 8 reading 0. The engine sees the divider, the target, control bits 31:16 as the length, bit 6 as enable, bit 4 as master, bit 1 as receive direction and bit 0 as 10-bit addressing.
- R3: A write to the command register (0x2) updates the command byte output. When written bit 7 is 1, the launch output is high for exactly the one cycle after the write.
- R4: Bytes written to 0x4 leave on the engine byte output in write order. Each byte is valid in the cycle after its engine pop. A pop of an empty transmit FIFO yields 0.
- R5: The transmit FIFO holds at most 128 bytes. A write to a full FIFO is dropped and sets status bit 4.
- R6: Bytes pushed by the engine read back from 0x5 in push order. A read of an empty receive FIFO returns 0 and leaves the count unchanged.
- R7: The count register (0xC) returns the receive occupancy in bits 7:0 and the transmit occupancy in bits 15:8.
- R8: A write to 0x6 with bit 16 set empties both FIFOs. Bits 15:8 of that register hold the receive threshold and read back.
- R9: Status bit 2 is set while the threshold is nonzero and the receive count is at least the threshold.
- R10: Status bits are set by engine events and FIFO conditions:
  - engine events: address NACK sets bit 25, address acknowledged sets bit 13, data done sets bit 12, arbitration lost sets bit 11, bus error sets bit 0;
  - FIFO conditions: an accepted receive push sets bit 5, and popping the last transmit byte sets bit 3.
- R11: Writing 0xE clears the status bits written as 1 and keeps the others. A set in the same cycle wins over the clear.
- R12: The interrupt goes high one cycle after a status bit is set whose enable bit in 0xD is set. It goes low one cycle after no such bit remains.
- R13: Writing control with bit 8 set clears every register, both FIFOs and all status on the next cycle. Bit 8 reads 1 only in that one intervening cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |
| eng_div | output | 32 | Clock divider value |
| eng_len | output | 16 | Transfer byte count |
| eng_enable | output | 1 | Controller enable |
| eng_master | output | 1 | Master mode |
| eng_rx_dir | output | 1 | Transfer direction is read |
| eng_addr10 | output | 1 | 10-bit target addressing |
| eng_target | output | 32 | Target address word |
| eng_cmd | output | 8 | Last command byte |
| eng_go | output | 1 | Launch pulse |
| eng_txpop | input | 1 | Engine takes a transmit byte |
| eng_txbyte | output | 8 | Transmit byte, valid the cycle after a pop |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rxpush | input | 1 | Engine delivers a receive byte |
| eng_rxbyte | input | 8 | Receive byte |
| eng_rx_full | output | 1 | Receive FIFO full |
| eng_stat | input | 32 | Engine state, read at offset 0x3 |
| eng_nack | input | 1 | Address not acknowledged event |
| eng_addr_ack | input | 1 | Address acknowledged event |
| eng_done | input | 1 | Transfer complete event |
| eng_arb_lost | input | 1 | Arbitration lost event |
| eng_bus_err | input | 1 | Bus error event |

## Verification
Configuration writes reach the engine outputs at the write's own clock edge, and read data appears one edge after the read strobe. Status bits update at the edge of the triggering event, except the threshold bit, which follows the occupancy one edge later. The interrupt follows the status by one further edge, and soft reset takes effect one edge after its write. The bench drives on falling edges and samples at the falling edge that follows the required number of rising edges. Where a result lags, the bench inserts explicit idle cycles and checks both the cycle before the change and the cycle after it. A seeded random phase interleaves pushes, pops, writes and count reads against queue models of both FIFOs.

// File: rtl/i2cm_csr_pkg.sv
`timescale 1ns/1ps
package i2cm_csr_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIV  = 5'h00,
    RA_CTRL = 5'h01,
    RA_CMD  = 5'h02,
    RA_STAT = 5'h03,
    RA_TXQ  = 5'h04,
    RA_RXQ  = 5'h05,
    RA_QCTL = 5'h06,
    RA_TGT  = 5'h0A,
    RA_CNT  = 5'h0C,
    RA_IEN  = 5'h0D,
    RA_IST  = 5'h0E
  } reg_addr_e;

  // status / enable bit positions
  localparam int B_NACK  = 25;
  localparam int B_AACK  = 13;
  localparam int B_DONE  = 12;
  localparam int B_ARB   = 11;
  localparam int B_RXRDY = 5;
  localparam int B_FULL  = 4;
  localparam int B_EMPTY = 3;
  localparam int B_THR   = 2;
  localparam int B_BERR  = 0;

  localparam logic [31:0] IRQ_MASK = (32'd1 << B_NACK) | (32'd1 << B_AACK) |
    (32'd1 << B_DONE) | (32'd1 << B_ARB) | (32'd1 << B_RXRDY) |
    (32'd1 << B_FULL) | (32'd1 << B_EMPTY) | (32'd1 << B_THR) | (32'd1 << B_BERR);

  // control and command fields
  localparam int C_SRST   = 8;
  localparam int C_EN     = 6;
  localparam int C_MST    = 4;
  localparam int C_RXDIR  = 1;
  localparam int C_A10    = 0;
  localparam int CMD_GO   = 7;
  localparam int Q_FLUSH  = 16;
endpackage

// File: rtl/i2cm_csr_fifo.sv
`timescale 1ns/1ps
module i2cm_csr_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (pop) dout <= empty ? '0 : mem[rptr];
      if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/i2cm_csr_irq.sv
`timescale 1ns/1ps
module i2cm_csr_irq
  import i2cm_csr_pkg::*;
(
  input  logic        clk,
  input  logic        clr,
  input  logic        ien_we,
  input  logic        ist_we,
  input  logic [31:0] wdata,
  input  logic [31:0] set_vec,
  output logic [31:0] ien,
  output logic [31:0] ist,
  output logic        irq
);
  always_ff @(posedge clk) begin
    if (clr) begin
      ien <= '0;
      ist <= '0;
      irq <= 1'b0;
    end else begin
      if (ien_we) ien <= wdata & IRQ_MASK;
      ist <= (ist & ~(ist_we ? wdata : 32'd0)) | (set_vec & IRQ_MASK);
      irq <= |(ist & ien);
    end
  end
endmodule

// File: rtl/i2cm_csr_front.sv
`timescale 1ns/1ps
module i2cm_csr_front
  import i2cm_csr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic [31:0]       eng_div,
  output logic [15:0]       eng_len,
  output logic              eng_enable,
  output logic              eng_master,
  output logic              eng_rx_dir,
  output logic              eng_addr10,
  output logic [31:0]       eng_target,
  output logic [7:0]        eng_cmd,
  output logic              eng_go,
  input  logic              eng_txpop,
  output logic [7:0]        eng_txbyte,
  output logic              eng_tx_empty,
  input  logic              eng_rxpush,
  input  logic [7:0]        eng_rxbyte,
  output logic              eng_rx_full,
  input  logic [31:0]       eng_stat,
  input  logic              eng_nack,
  input  logic              eng_addr_ack,
  input  logic              eng_done,
  input  logic              eng_arb_lost,
  input  logic              eng_bus_err
);
  logic [31:0]      div_q, ctrl_q, tgt_q;
  logic [7:0]       cmd_q, thr_q;
  logic             go_q, srst_q, clr, qclr;
  logic             wr_div, wr_ctrl, wr_cmd, wr_txq, wr_qctl, wr_tgt, wr_ien, wr_ist;
  logic             rd_rxq, flush;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       rx_dout;
  logic [31:0]      set_vec, ien, ist;
  logic [31:0]      rdata_q;
  logic             rsel_fifo;

  assign clr     = rst | srst_q;
  assign wr_div  = wr_en && (addr == RA_DIV);
  assign wr_ctrl = wr_en && (addr == RA_CTRL);
  assign wr_cmd  = wr_en && (addr == RA_CMD);
  assign wr_txq  = wr_en && (addr == RA_TXQ);
  assign wr_qctl = wr_en && (addr == RA_QCTL);
  assign wr_tgt  = wr_en && (addr == RA_TGT);
  assign wr_ien  = wr_en && (addr == RA_IEN);
  assign wr_ist  = wr_en && (addr == RA_IST);
  assign rd_rxq  = rd_en && (addr == RA_RXQ);
  assign flush   = wr_qctl && wdata[Q_FLUSH];
  assign qclr    = clr | flush;

  // configuration registers
  always_ff @(posedge clk) begin
    if (clr) begin
      div_q  <= '0;
      ctrl_q <= '0;
      tgt_q  <= '0;
      cmd_q  <= '0;
      thr_q  <= '0;
      go_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (wr_div) div_q <= wdata;
      if (wr_ctrl) begin
        if (wdata[C_SRST]) srst_q <= 1'b1;
        else               ctrl_q <= wdata & ~(32'd1 << C_SRST);
      end
      if (wr_cmd) begin
        cmd_q <= wdata[7:0];
        go_q  <= wdata[CMD_GO];
      end
      if (wr_qctl) thr_q <= wdata[15:8];
      if (wr_tgt)  tgt_q <= wdata;
    end
  end

  i2cm_csr_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .clr(qclr), .push(wr_txq), .din(wdata[7:0]), .pop(eng_txpop),
    .dout(eng_txbyte), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cm_csr_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .clr(qclr), .push(eng_rxpush), .din(eng_rxbyte), .pop(rd_rxq),
    .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // status set sources
  always_comb begin
    set_vec          = '0;
    set_vec[B_NACK]  = eng_nack;
    set_vec[B_AACK]  = eng_addr_ack;
    set_vec[B_DONE]  = eng_done;
    set_vec[B_ARB]   = eng_arb_lost;
    set_vec[B_BERR]  = eng_bus_err;
    set_vec[B_RXRDY] = eng_rxpush && !rx_full;
    set_vec[B_FULL]  = wr_txq && tx_full;
    set_vec[B_EMPTY] = eng_txpop && (tx_cnt == CNT_W'(1)) && !wr_txq;
    set_vec[B_THR]   = (thr_q != 8'd0) && (32'(rx_cnt) >= 32'(thr_q));
  end

  i2cm_csr_irq u_irq (
    .clk(clk), .clr(clr), .ien_we(wr_ien), .ist_we(wr_ist), .wdata(wdata),
    .set_vec(set_vec), .ien(ien), .ist(ist), .irq(irq)
  );

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      rsel_fifo <= 1'b0;
    end else if (rd_en) begin
      rsel_fifo <= (addr == RA_RXQ);
      case (addr)
        RA_DIV:  rdata_q <= div_q;
        RA_CTRL: rdata_q <= ctrl_q | (32'(srst_q) << C_SRST);
        RA_CMD:  rdata_q <= {24'd0, cmd_q};
        RA_STAT: rdata_q <= eng_stat;
        RA_QCTL: rdata_q <= {16'd0, thr_q, 8'd0};
        RA_TGT:  rdata_q <= tgt_q;
        RA_CNT:  rdata_q <= {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
        RA_IEN:  rdata_q <= ien;
        RA_IST:  rdata_q <= ist;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata        = rsel_fifo ? {24'd0, rx_dout} : rdata_q;
  assign eng_div      = div_q;
  assign eng_len      = ctrl_q[31:16];
  assign eng_enable   = ctrl_q[C_EN];
  assign eng_master   = ctrl_q[C_MST];
  assign eng_rx_dir   = ctrl_q[C_RXDIR];
  assign eng_addr10   = ctrl_q[C_A10];
  assign eng_target   = tgt_q;
  assign eng_cmd      = cmd_q;
  assign eng_go       = go_q;
  assign eng_tx_empty = tx_empty;
  assign eng_rx_full  = rx_full;
endmodule

// File: rtl/i2cm_csr_front_chk.sv
`timescale 1ns/1ps
module i2cm_csr_front_chk
  import i2cm_csr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              eng_go,
  input logic              eng_nack,
  input logic              eng_rxpush,
  input logic              irq,
  input logic              srst_q,
  input logic [31:0]       ist,
  input logic [31:0]       ien,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);
  assert_go_cause_R3: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> $past(wr_en && (addr == RA_CMD) && wdata[CMD_GO]));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == RA_RXQ) && (rx_cnt == '0) && !eng_rxpush) |=> (rx_cnt == '0));

  assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && (addr == RA_IST) && wdata[B_NACK] && !eng_nack) |-> !ist[B_NACK]);

  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(|(ist & ien)) && !$past(srst_q)));

  assert_soft_clear_R13: assert property (@(posedge clk) disable iff (rst)
    $past(srst_q) |-> (ist == '0 && ien == '0 && tx_cnt == '0 && rx_cnt == '0 && !srst_q));
endmodule

bind i2cm_csr_front i2cm_csr_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .eng_go(eng_go), .eng_nack(eng_nack), .eng_rxpush(eng_rxpush), .irq(irq),
  .srst_q(srst_q), .ist(ist), .ien(ien), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/i2cm_csr_front_bench.sv
`timescale 1ns/1ps
module i2cm_csr_front_bench;
  import i2cm_csr_pkg::*;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, wr_en, rd_en, irq, eng_go, eng_txpop, eng_tx_empty, eng_rxpush, eng_rx_full;
  logic eng_enable, eng_master, eng_rx_dir, eng_addr10;
  logic eng_nack, eng_addr_ack, eng_done, eng_arb_lost, eng_bus_err;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata, eng_div, eng_target, eng_stat;
  logic [15:0] eng_len;
  logic [7:0]  eng_cmd, eng_txbyte, eng_rxbyte;

  int n_chk = 0;
  int n_fail = 0;

  i2cm_csr_front #(.DEPTH(DEPTH)) u_i2cm_csr_front (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .eng_div(eng_div), .eng_len(eng_len),
    .eng_enable(eng_enable), .eng_master(eng_master), .eng_rx_dir(eng_rx_dir),
    .eng_addr10(eng_addr10), .eng_target(eng_target), .eng_cmd(eng_cmd), .eng_go(eng_go),
    .eng_txpop(eng_txpop), .eng_txbyte(eng_txbyte), .eng_tx_empty(eng_tx_empty),
    .eng_rxpush(eng_rxpush), .eng_rxbyte(eng_rxbyte), .eng_rx_full(eng_rx_full),
    .eng_stat(eng_stat), .eng_nack(eng_nack), .eng_addr_ack(eng_addr_ack),
    .eng_done(eng_done), .eng_arb_lost(eng_arb_lost), .eng_bus_err(eng_bus_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rxp(input logic [7:0] b);
    eng_rxpush = 1'b1; eng_rxbyte = b;
    @(negedge clk);
    eng_rxpush = 1'b0;
  endtask

  task automatic txp(output logic [7:0] b);
    eng_txpop = 1'b1;
    @(negedge clk);
    eng_txpop = 1'b0;
    b = eng_txbyte;
  endtask

  // expected count word from model occupancies
  function automatic logic [31:0] cnt_word(input int tx, input int rx);
    return {16'd0, 8'(tx), 8'(rx)};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    logic [7:0]  txm[$];
    logic [7:0]  rxm[$];
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    eng_txpop = 1'b0; eng_rxpush = 1'b0; eng_rxbyte = '0; eng_stat = 32'h0000_00C3;
    eng_nack = 1'b0; eng_addr_ack = 1'b0; eng_done = 1'b0; eng_arb_lost = 1'b0; eng_bus_err = 1'b0;
    void'($urandom(32'd20517));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 go", {31'd0, eng_go}, 0);
    rd(RA_DIV, v);  chk("R1 div", v, 0);
    rd(RA_CTRL, v); chk("R1 ctrl", v, 0);
    rd(RA_CNT, v);  chk("R1 cnt", v, 0);
    rd(RA_IST, v);  chk("R1 ist", v, 0);
    rd(RA_IEN, v);  chk("R1 ien", v, 0);

    // R2 configuration
    wr(RA_DIV, 32'h1234_5678);
    wr(RA_TGT, 32'h0000_00A5);
    wr(RA_CTRL, 32'h0010_0053);
    rd(RA_DIV, v);  chk("R2 div", v, 32'h1234_5678);
    rd(RA_TGT, v);  chk("R2 tgt", v, 32'h0000_00A5);
    rd(RA_CTRL, v); chk("R2 ctrl", v, 32'h0010_0053);
    rd(RA_STAT, v); chk("R2 stat passthrough", v, 32'h0000_00C3);
    chk("R2 eng fields", {eng_div, eng_len, eng_enable, eng_master, eng_rx_dir, eng_addr10} == {32'h1234_5678, 16'h0010, 4'b1111}, 1);
    chk("R2 eng target", eng_target, 32'hA5);

    // R3 command launch
    wr(RA_CMD, 32'h0000_00B0);
    chk("R3 go high", {31'd0, eng_go}, 1);
    chk("R3 cmd", {24'd0, eng_cmd}, 32'hB0);
    @(negedge clk);
    chk("R3 go one cycle", {31'd0, eng_go}, 0);
    wr(RA_CMD, 32'h0000_0050);
    chk("R3 no go without start", {31'd0, eng_go}, 0);
    chk("R3 cmd update", {24'd0, eng_cmd}, 32'h50);

    // R4 / R7 / R10 transmit order and empty event
    wr(RA_IST, 32'hFFFF_FFFF);
    wr(RA_TXQ, 32'h11); wr(RA_TXQ, 32'h22); wr(RA_TXQ, 32'h33);
    rd(RA_CNT, v); chk("R7 tx count", v, cnt_word(3, 0));
    txp(b); chk("R4 first", {24'd0, b}, 32'h11);
    txp(b); chk("R4 second", {24'd0, b}, 32'h22);
    rd(RA_IST, v); chk("R10 empty not yet", v & 32'h8, 0);
    txp(b); chk("R4 third", {24'd0, b}, 32'h33);
    rd(RA_IST, v); chk("R10 empty bit3", v & 32'h8, 32'h8);
    chk("R4 empty flag", {31'd0, eng_tx_empty}, 1);
    txp(b); chk("R4 pop empty zero", {24'd0, b}, 0);

    // R5 transmit full
    wr(RA_IST, 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) wr(RA_TXQ, 32'(i + 7));
    rd(RA_IST, v); chk("R5 not full yet", v & 32'h10, 0);
    rd(RA_CNT, v); chk("R5 count at depth", v, cnt_word(DEPTH, 0));
    wr(RA_TXQ, 32'hEE);
    rd(RA_IST, v); chk("R5 full bit4", v & 32'h10, 32'h10);
    rd(RA_CNT, v); chk("R5 dropped", v, cnt_word(DEPTH, 0));
    txp(b); chk("R5 head kept", {24'd0, b}, 32'd7);

    // R8 flush and threshold field
    rxp(8'h01); rxp(8'h02);
    wr(RA_QCTL, 32'h0001_0000);
    rd(RA_CNT, v); chk("R8 flush both", v, 0);
    wr(RA_QCTL, 32'h0000_0500);
    rd(RA_QCTL, v); chk("R8 threshold field", v, 32'h0000_0500);

    // R6 receive order and empty read
    rd(RA_RXQ, v); chk("R6 empty read zero", v, 0);
    rd(RA_CNT, v); chk("R6 empty read no count change", v, 0);
    rxp(8'hAB); rxp(8'hCD);
    rd(RA_CNT, v); chk("R7 rx count", v, cnt_word(0, 2));
    rd(RA_RXQ, v); chk("R6 first", v, 32'hAB);
    rd(RA_RXQ, v); chk("R6 second", v, 32'hCD);
    rd(RA_RXQ, v); chk("R6 drained zero", v, 0);

    // R9 threshold status
    wr(RA_QCTL, 32'h0001_0400);
    wr(RA_IST, 32'hFFFF_FFFF);
    rxp(8'h10); rxp(8'h11); rxp(8'h12);
    @(negedge clk);
    rd(RA_IST, v); chk("R9 below threshold", v & 32'h4, 0);
    rxp(8'h13);
    @(negedge clk);
    rd(RA_IST, v); chk("R9 at threshold", v & 32'h4, 32'h4);
    wr(RA_QCTL, 32'h0000_0000);
    wr(RA_IST, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(RA_IST, v); chk("R9 zero threshold inert", v & 32'h4, 0);

    // R10 engine events and receive ready
    wr(RA_IST, 32'hFFFF_FFFF);
    eng_nack = 1'b1;     @(negedge clk); eng_nack = 1'b0;
    eng_addr_ack = 1'b1; @(negedge clk); eng_addr_ack = 1'b0;
    eng_done = 1'b1;     @(negedge clk); eng_done = 1'b0;
    eng_arb_lost = 1'b1; @(negedge clk); eng_arb_lost = 1'b0;
    eng_bus_err = 1'b1;  @(negedge clk); eng_bus_err = 1'b0;
    rd(RA_IST, v); chk("R10 event bits", v, 32'h0200_3801);

    // R11 write one to clear
    wr(RA_IST, 32'h0000_1001);
    rd(RA_IST, v); chk("R11 selective clear", v, 32'h0200_2800);
    wr_en = 1'b1; addr = RA_IST; wdata = 32'h0000_1000; eng_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0;
    rd(RA_IST, v); chk("R11 set wins", v & 32'h1000, 32'h1000);
    rxp(8'h55);
    rd(RA_IST, v); chk("R10 rx ready bit5", v & 32'h20, 32'h20);

    // R12 interrupt timing
    wr(RA_IST, 32'hFFFF_FFFF);
    wr(RA_IEN, 32'h0000_1000);
    chk("R12 idle low", {31'd0, irq}, 0);
    eng_arb_lost = 1'b1; @(negedge clk); eng_arb_lost = 1'b0;
    @(negedge clk);
    chk("R12 disabled cause", {31'd0, irq}, 0);
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk("R12 not same cycle", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R12 raised", {31'd0, irq}, 1);
    wr(RA_IST, 32'h0000_1000);
    chk("R12 lags clear", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R12 dropped", {31'd0, irq}, 0);

    // R13 soft reset
    wr(RA_CTRL, 32'h0020_0010);
    wr(RA_DIV, 32'h99);
    wr(RA_IEN, 32'hFFFF_FFFF);
    wr(RA_TXQ, 32'h3C);
    rxp(8'h77);
    wr(RA_CTRL, 32'h0000_0100);
    rd(RA_CTRL, v); chk("R13 bit8 visible", v, 32'h0020_0110);
    rd(RA_CTRL, v); chk("R13 ctrl cleared", v, 0);
    rd(RA_DIV, v);  chk("R13 div cleared", v, 0);
    rd(RA_CNT, v);  chk("R13 fifos cleared", v, 0);
    rd(RA_IST, v);  chk("R13 status cleared", v, 0);
    rd(RA_IEN, v);  chk("R13 enable cleared", v, 0);
    chk("R13 irq low", {31'd0, irq}, 0);

    // random mix against queue models (R4 R6 R7)
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 5);
      d  = 8'($urandom);
      case (op)
        0: begin
          rxp(d);
          if (rxm.size() < DEPTH) rxm.push_back(d);
        end
        1: begin
          logic [7:0] e;
          e = (rxm.size() > 0) ? rxm.pop_front() : 8'd0;
          rd(RA_RXQ, v); chk("R6 random read", v, {24'd0, e});
        end
        2: begin
          wr(RA_TXQ, {24'd0, d});
          if (txm.size() < DEPTH) txm.push_back(d);
        end
        3: begin
          logic [7:0] e;
          e = (txm.size() > 0) ? txm.pop_front() : 8'd0;
          txp(b); chk("R4 random pop", {24'd0, b}, {24'd0, e});
        end
        default: begin
          rd(RA_CNT, v); chk("R7 random count", v, cnt_word(txm.size(), rxm.size()));
        end
      endcase
    end

    report();
  end
endmodule